// File: doc/BRIEF.md
# Transfer Controller Status and Gating Register

This block is a 16-bit control/status register that sits in front of a data transfer engine. It decides whether a new transfer may start. It holds two sticky error flags and a software activation enable. One flag records a non-maskable interrupt event. The other records an address error reported by the transfer controller.

A host reads and writes the register over a simple synchronous bus with a select line, separate read and write strobes, and 16-bit data in each direction. Each error flag can only be cleared by a deliberate read-then-clear sequence. The host must first read the register while the flag is 1, and then write 0 to that flag.

While either flag is set, no new transfer is permitted. One exception applies: a transfer that is already running with its NMI-mask attribute set keeps its permit until it finishes. The vector address field is not held here, and the transfer engine is a separate block.

Top module: `xfer_gate_csr`

## Requirements
- R1: Bits 15..11 and 7..0 always read as 0, and values written to them are ignored.
- R2: After reset, the readback is 0x0000, and `permit` follows only `req_en` and the engine inputs.
- R3: A cycle with `nmi_evt` high sets bit 10 (NMI flag). A cycle with `aerr_evt` high sets bit 9 (address-error flag).
- R4: Writing 0 to a flag clears it only if a read returned that flag as 1 after the most recent write. Without such a read, writing 0 leaves the flag at 1.
- R5: Writing 1 to bit 10 or bit 9 never sets a flag.
- R6: If a set event and a valid clearing write reach the same flag in the same cycle, the flag stays 1.
- R7: Any register write disarms both flags. A clear therefore needs a fresh read after every write.
- R8: While bit 10 or bit 9 is 1, `permit` is low unless R9 applies, even when `req_en` or bit 8 is 1.
- R9: While `eng_busy` and `eng_nmi_mask` are both high, `permit` is high whatever the flags hold.
- R10: Bit 8 (software activation enable) reads back as written. When both flags are 0, it raises `permit` just as `req_en` does.
- R11: `rdata` is 0 in every cycle that is not a selected read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sel | input | 1 | Register select |
| wr_en | input | 1 | Write strobe, qualified by `sel` |
| rd_en | input | 1 | Read strobe, qualified by `sel` |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid combinationally during a selected read |
| nmi_evt | input | 1 | NMI event pulse |
| aerr_evt | input | 1 | Address-error event from the controller |
| req_en | input | 1 | Hardware request enable |
| eng_busy | input | 1 | The transfer engine has a transfer in progress |
| eng_nmi_mask | input | 1 | The running transfer carries the NMI-mask attribute |
| sw_act_en | output | 1 | Current value of the software activation enable |
| permit | output | 1 | A transfer may start or continue |

## Verification
The bench builds the block with its default parameters: a 16-bit word, the flags at bits 10 and 9, the enable at bit 8, and a two-stage reset synchronizer. The fixed positions let the bench state every readback as an exact hex value. Each constant-0 field is then checked directly against the all-ones writes.

The scenarios cover several cases:
- the read-arm/disarm ordering, including a write of 1 placed between the arming read and the clearing write;
- a set event that lands in the same cycle as a valid clear;
- the masked in-flight exception, with each flag set on its own.

// File: rtl/csr_gate_pkg.sv
package csr_gate_pkg;
  localparam int REG_W   = 16;
  localparam int NMI_POS = 10;
  localparam int AE_POS  = 9;
  localparam int SWE_POS = 8;
  localparam int N_FLAGS = 2;
  typedef logic [REG_W-1:0] csr_word_t;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic bus_rd,
  input  logic bus_wr,
  input  logic wr_bit,
  output logic flag
);
  logic flag_q, flag_d;
  logic arm_q, arm_d;
  logic clr_ok;

  always_comb begin
    clr_ok = bus_wr && !wr_bit && arm_q;
    flag_d = flag_q;
    if (set_evt)     flag_d = 1'b1;
    else if (clr_ok) flag_d = 1'b0;
    arm_d = arm_q;
    if (bus_wr)                arm_d = 1'b0;
    else if (bus_rd && flag_q) arm_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag = flag_q;

  // R4: a flag may only fall after an arming read
  a_r4_clear_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(arm_q));
  // R6: an event always leaves the flag set on the next cycle
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q);
  // R7: arm never survives a write
  a_r7_write_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> !arm_q);
endmodule

// File: rtl/xfer_gate_csr.sv
module xfer_gate_csr
  import csr_gate_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             nmi_evt,
  input  logic             aerr_evt,
  input  logic             req_en,
  input  logic             eng_busy,
  input  logic             eng_nmi_mask,
  output logic             sw_act_en,
  output logic             permit
);
  logic               srst_n;
  logic               bus_rd, bus_wr;
  logic [N_FLAGS-1:0] evt_vec, flag_vec;
  logic               swe_q, swe_d;
  logic               blocked, start_ok, cont_ok;

  rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  assign bus_rd  = sel && rd_en;
  assign bus_wr  = sel && wr_en;
  assign evt_vec = {aerr_evt, nmi_evt};

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    localparam int POS = (g == 0) ? NMI_POS : AE_POS;
    sticky_flag u_flag (
      .clk(clk), .rst_n(srst_n), .set_evt(evt_vec[g]),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .wr_bit(wdata[POS]),
      .flag(flag_vec[g])
    );
  end

  always_comb begin
    swe_d = swe_q;
    if (bus_wr) swe_d = wdata[SWE_POS];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) swe_q <= 1'b0;
    else         swe_q <= swe_d;
  end

  always_comb begin
    rdata = '0;
    if (bus_rd) begin
      rdata[NMI_POS] = flag_vec[0];
      rdata[AE_POS]  = flag_vec[1];
      rdata[SWE_POS] = swe_q;
    end
  end

  assign blocked   = |flag_vec;
  assign start_ok  = !blocked && (req_en || swe_q);
  assign cont_ok   = eng_busy && eng_nmi_mask;
  assign permit    = start_ok || cont_ok;
  assign sw_act_en = swe_q;

  // R8: a raised flag blocks unless the masked in-flight case holds
  a_r8_flag_blocks: assert property (@(posedge clk) disable iff (!srst_n)
    (flag_vec != '0 && !(eng_busy && eng_nmi_mask)) |-> !permit);
  // R9: masked in-flight transfer always keeps its permit
  a_r9_masked_continues: assert property (@(posedge clk) disable iff (!srst_n)
    (eng_busy && eng_nmi_mask) |-> permit);
  // R3: NMI event registers into the flag
  a_r3_nmi_sets: assert property (@(posedge clk) disable iff (!srst_n)
    nmi_evt |=> flag_vec[0]);
  // R11: no data outside a selected read
  a_r11_idle_bus: assert property (@(posedge clk) disable iff (!srst_n)
    !bus_rd |-> (rdata == '0));
endmodule

// File: tb/tb_xfer_gate_csr.sv
module tb_xfer_gate_csr;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel, wr_en, rd_en;
  logic [15:0] wdata, rdata;
  logic        nmi_evt, aerr_evt, req_en, eng_busy, eng_nmi_mask;
  logic        sw_act_en, permit;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  xfer_gate_csr dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .nmi_evt(nmi_evt), .aerr_evt(aerr_evt),
    .req_en(req_en), .eng_busy(eng_busy), .eng_nmi_mask(eng_nmi_mask),
    .sw_act_en(sw_act_en), .permit(permit)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [15:0] v);
    @(negedge clk); sel = 1; wr_en = 1; wdata = v;
    @(negedge clk); sel = 0; wr_en = 0; wdata = '0;
  endtask

  task automatic reg_read(output logic [15:0] v);
    @(negedge clk); sel = 1; rd_en = 1; #1 v = rdata;
    @(negedge clk); sel = 0; rd_en = 0;
  endtask

  task automatic pulse_nmi();
    @(negedge clk); nmi_evt = 1; @(negedge clk); nmi_evt = 0;
  endtask

  task automatic pulse_ae();
    @(negedge clk); aerr_evt = 1; @(negedge clk); aerr_evt = 0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    reg_read(v); check("R2 readback", v, 16'h0000);
    check("R2 permit idle", {15'd0, permit}, 16'd0);
    req_en = 1; #1 check("R2 permit req", {15'd0, permit}, 16'd1); req_en = 0;
  endtask

  task automatic t_reserved();
    logic [15:0] v;
    reg_write(16'hFFFF); reg_read(v);
    check("R1 R10 all ones", v, 16'h0100);
    check("R10 sw out", {15'd0, sw_act_en}, 16'd1);
    #1 check("R10 permit sw", {15'd0, permit}, 16'd1);
    reg_write(16'h0000); reg_read(v); check("R1 zero", v, 16'h0000);
  endtask

  task automatic t_unread_clear();
    logic [15:0] v;
    pulse_ae(); reg_write(16'h0000); reg_read(v);
    check("R3 R4 unread write 0", v, 16'h0200);
    reg_write(16'h0000); reg_read(v); check("R4 armed clear", v, 16'h0000);
  endtask

  task automatic t_write1();
    logic [15:0] v;
    reg_write(16'h0600); reg_read(v); check("R5 write ones", v, 16'h0000);
  endtask

  task automatic t_rearm();
    logic [15:0] v;
    pulse_nmi(); reg_read(v); check("R3 nmi set", v, 16'h0400);
    reg_write(16'h0400); reg_write(16'h0000); reg_read(v);
    check("R7 disarmed", v, 16'h0400);
    reg_write(16'h0000); reg_read(v); check("R7 rearmed clear", v, 16'h0000);
  endtask

  task automatic t_set_wins();
    logic [15:0] v;
    pulse_nmi(); reg_read(v);
    @(negedge clk); sel = 1; wr_en = 1; wdata = 16'h0000; nmi_evt = 1;
    @(negedge clk); sel = 0; wr_en = 0; nmi_evt = 0;
    reg_read(v); check("R6 set wins", v, 16'h0400);
    reg_write(16'h0000); reg_read(v); check("R6 later clear", v, 16'h0000);
  endtask

  task automatic t_gating();
    logic [15:0] v;
    pulse_nmi(); req_en = 1; #1 check("R8 nmi blocks", {15'd0, permit}, 16'd0);
    eng_busy = 1; eng_nmi_mask = 1;
    #1 check("R9 masked keeps", {15'd0, permit}, 16'd1);
    eng_nmi_mask = 0; #1 check("R8 unmasked busy", {15'd0, permit}, 16'd0);
    reg_read(v); reg_write(16'h0000);
    pulse_ae(); #1 check("R8 ae blocks", {15'd0, permit}, 16'd0);
    eng_nmi_mask = 1; #1 check("R9 ae masked", {15'd0, permit}, 16'd1);
    eng_busy = 0; eng_nmi_mask = 0;
    @(negedge clk); sel = 0; rd_en = 1; #1 check("R11 unselected", rdata, 16'h0000);
    rd_en = 0;
    reg_read(v); reg_write(16'h0000); req_en = 0;
    #1 check("R8 cleared idle", {15'd0, permit}, 16'd0);
  endtask

  initial begin
    rst_n = 0; sel = 0; wr_en = 0; rd_en = 0; wdata = '0;
    nmi_evt = 0; aerr_evt = 0; req_en = 0; eng_busy = 0; eng_nmi_mask = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset(); t_reserved(); t_unread_clear(); t_write1();
    t_rearm(); t_set_wins(); t_gating();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule